// File: doc/BRIEF.md
# Watchdog and Clock-Monitor Reset Controller

This block supervises a small microcontroller. It holds an 8-bit control register and an 8-bit flag register, both reached through one shared register port. From these it decides when to ask for a system reset.

It can ask for a reset for two reasons:
- **Watchdog.** A counter is clocked by E-clock ticks and restarted by a service strobe. If it runs out, the block raises a one-cycle watchdog reset request.
- **Clock monitor.** An external detector reports a slow or stopped clock, and a stop-mode indication counts as a stopped clock. While the clock monitor is active, either one raises a one-cycle clock-monitor reset request.

Software can also force either reset, and it can disable both. What software may write depends on the mode. In normal mode some fields may be written once after reset and the test-related bits cannot be written at all. In special (test) mode every field can be written at any time.

The block also holds a real-time interrupt flag. An external rate generator sets it, and software clears it by writing a one to it.

Either reset request also returns every register of the block to its mode-dependent reset value. This happens on the clock edge after the request pulse.

Top module: `wdog_clkmon_ctrl`

## Requirements
- R1: Register addressing and reset values.
  - `addr_i`=0 selects the flag register and `addr_i`=1 selects the control register.
  - Control layout, bit 7 down to bit 0: monitor enable, monitor force-enable, force monitor reset, force watchdog reset, reset disable, then a 3-bit rate field in bits 2:0.
  - After reset the control register reads 0x01 in normal mode and 0x09 in special mode.
  - The flag register reads 0x00 after reset.
- R2: The monitor enable bit (bit 7) takes the written value on every control write, in either mode.
- R3: In normal mode, the first control write after a reset loads the force-enable bit and the rate field, and later writes leave both unchanged. In special mode both fields take every write.
- R4: In normal mode, control writes leave bits 5, 4 and 3 unchanged. In special mode these bits take every write.
- R5: While the reset disable bit is set, neither `cop_rst_o` nor `cm_rst_o` is ever asserted, whatever the other bits, inputs or timer do.
- R6: A set force-watchdog bit raises `cop_rst_o` on the next cycle only if the rate field is nonzero and reset disable is clear. With a rate of 000 it has no effect.
- R7: Watchdog timing.
  - A rate of 000 disables the watchdog.
  - For codes 1 to 7 the timeout is 2^(PRE_W+e) E-ticks after the last service, where e is 2, 4, 6, 8, 9, 10, 11 in turn.
  - `service_i` restarts the count.
  - On timeout, `cop_rst_o` pulses for one cycle, on the cycle after the expiring tick.
- R8: The clock monitor is active when the enable or force-enable bit is set. While it is active and reset disable is clear, `slow_clk_i` or `stop_i` produces a one-cycle `cm_rst_o` pulse on the next cycle. While it is inactive these inputs have no effect.
- R9: The force-monitor-reset bit raises `cm_rst_o` only while the monitor is active and reset disable is clear.
- R10: Real-time interrupt flag.
  - The flag sits in bit 7 of the flag register, and bits 6:0 read 0.
  - `rti_timeout_i` sets the flag.
  - Writing the flag register with bit 7 = 1 clears the flag, and writing it with bit 7 = 0 leaves the flag unchanged.
  - When a set and a clear happen in the same cycle, the set wins.
- R11: On the edge after any reset request pulse, the control register returns to its mode reset value, the flag clears, the watchdog count restarts and the normal-mode write-once lock reopens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| special_mode_i | input | 1 | 1 = special (test) mode, 0 = normal mode |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 1 | Register select: 0 = flag, 1 = control |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the selected register |
| etick_i | input | 1 | E-clock tick enable |
| slow_clk_i | input | 1 | Slow or stopped clock detected |
| stop_i | input | 1 | Stop mode indication |
| service_i | input | 1 | Watchdog service strobe |
| rti_timeout_i | input | 1 | Real-time interrupt timeout event |
| cop_rst_o | output | 1 | Watchdog reset request, one-cycle pulse |
| cm_rst_o | output | 1 | Clock-monitor reset request, one-cycle pulse |
| rti_flag_o | output | 1 | Real-time interrupt flag |

## Verification
The bench checks that a second normal-mode write cannot change the force-enable bit or the rate field. A design without the lock would show the new value on readback. It also checks that the lock reopens after a reset request, which a lock tied only to the reset pin would miss.

Timing is checked cycle by cycle:
- Watchdog timeouts are checked for two rate codes, and the bench confirms that a service strobe in mid-count moves the pulse. An off-by-one counter or a wrong divide exponent shifts the pulse by at least one cycle.
- Reset requests must last exactly one cycle. A design that does not suppress the request while its own reset is being applied would show a two-cycle pulse.

Reset disable, a zero rate and an inactive monitor are each checked for silence on both request outputs. A set and a clear of the interrupt flag in the same cycle must leave the flag set.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int RATE_W  = 3;
  localparam int MAX_EXP = 11;

  typedef struct packed {
    logic              mon_en;
    logic              mon_force_en;
    logic              mon_force_rst;
    logic              wd_force_rst;
    logic              rst_dis;
    logic [RATE_W-1:0] rate;
  } ctrl_t;

  // extra divide exponent for a rate code, 0 = watchdog off
  function automatic int rate_exp(logic [RATE_W-1:0] code);
    int e;
    if (code == '0)          e = 0;
    else if (code <= 3'd4)   e = 2 * int'(code);
    else                     e = int'(code) + 4;
    return e;
  endfunction

  function automatic ctrl_t ctrl_rst_val(logic special);
    ctrl_t r;
    r         = '0;
    r.rate    = 3'd1;
    r.rst_dis = special;
    return r;
  endfunction
endpackage

// File: rtl/wdog_ctl_reg.sv
module wdog_ctl_reg
  import wdog_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        special_mode_i,
  input  logic        sys_rst_i,
  input  logic        wr_i,
  input  logic [7:0]  wdata_i,
  output ctrl_t       ctrl_o
);
  ctrl_t ctrl_q, wd, wval, rst_val;
  logic  lock_q;

  assign rst_val = ctrl_rst_val(special_mode_i);
  assign wd      = ctrl_t'(wdata_i);

  always_comb begin
    wval        = ctrl_q;
    wval.mon_en = wd.mon_en;
    if (special_mode_i || !lock_q) begin
      wval.mon_force_en = wd.mon_force_en;
      wval.rate         = wd.rate;
    end
    if (special_mode_i) begin
      wval.mon_force_rst = wd.mon_force_rst;
      wval.wd_force_rst  = wd.wd_force_rst;
      wval.rst_dis       = wd.rst_dis;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= rst_val;
      lock_q <= 1'b0;
    end else if (sys_rst_i) begin
      ctrl_q <= rst_val;
      lock_q <= 1'b0;
    end else if (wr_i) begin
      ctrl_q <= wval;
      lock_q <= 1'b1;
    end
  end

  assign ctrl_o = ctrl_q;

  p_cme_wr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !sys_rst_i) |=> (ctrl_q.mon_en == $past(wdata_i[7])));

  p_write_once_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && lock_q && !special_mode_i && !sys_rst_i)
      |=> ($stable(ctrl_q.mon_force_en) && $stable(ctrl_q.rate)));

  p_protected_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !special_mode_i && !sys_rst_i)
      |=> $stable({ctrl_q.mon_force_rst, ctrl_q.wd_force_rst, ctrl_q.rst_dis}));

  p_sys_reload_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_i |=> (ctrl_q == $past(rst_val)));
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int PRE_W = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sys_rst_i,
  input  logic              etick_i,
  input  logic              service_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              expire_o
);
  localparam int CNT_W  = PRE_W + MAX_EXP;
  localparam int N_CODE = 1 << RATE_W;

  logic [CNT_W-1:0]  cnt_q;
  logic [N_CODE-1:0] hit;

  assign hit[0] = 1'b0;
  for (genvar g = 1; g < N_CODE; g++) begin : g_rate
    localparam int SPAN = PRE_W + rate_exp(RATE_W'(g));
    assign hit[g] = &cnt_q[SPAN-1:0];
  end

  assign expire_o = etick_i && !service_i && hit[rate_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (sys_rst_i || service_i) cnt_q <= '0;
    else if (etick_i)                cnt_q <= cnt_q + CNT_W'(1);
  end

  p_expire_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> !expire_o);
endmodule

// File: rtl/clkmon_ctl.sv
module clkmon_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sys_rst_i,
  input  logic mon_en_i,
  input  logic mon_force_en_i,
  input  logic mon_force_rst_i,
  input  logic rst_dis_i,
  input  logic slow_clk_i,
  input  logic stop_i,
  output logic cm_rst_o
);
  logic active, req, cm_q;

  assign active = mon_en_i || mon_force_en_i;
  assign req    = active && !rst_dis_i && (slow_clk_i || stop_i || mon_force_rst_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cm_q <= 1'b0;
    else         cm_q <= req && !sys_rst_i;
  end

  assign cm_rst_o = cm_q;

  p_cm_inactive_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mon_en_i || mon_force_en_i) |=> !cm_rst_o);

  p_cm_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cm_rst_o |=> !cm_rst_o);
endmodule

// File: rtl/rti_flag.sv
module rti_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sys_rst_i,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        flag_q <= 1'b0;
    else if (sys_rst_i) flag_q <= 1'b0;
    else if (set_i)     flag_q <= 1'b1;
    else if (clr_i)     flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  p_rti_set_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !sys_rst_i) |=> flag_o);

  p_rti_clr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/wdog_clkmon_ctrl.sv
module wdog_clkmon_ctrl
  import wdog_pkg::*;
#(
  parameter int PRE_W = 13
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       special_mode_i,
  input  logic       wr_en_i,
  input  logic       addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic       etick_i,
  input  logic       slow_clk_i,
  input  logic       stop_i,
  input  logic       service_i,
  input  logic       rti_timeout_i,
  output logic       cop_rst_o,
  output logic       cm_rst_o,
  output logic       rti_flag_o
);
  ctrl_t ctrl;
  logic  sys_rst, expire, wd_on, cop_req, cop_q, cm_q, flag;

  assign sys_rst = cop_q || cm_q;

  wdog_ctl_reg u_ctl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .special_mode_i (special_mode_i),
    .sys_rst_i      (sys_rst),
    .wr_i           (wr_en_i && addr_i),
    .wdata_i        (wdata_i),
    .ctrl_o         (ctrl)
  );

  wdog_timer #(.PRE_W(PRE_W)) u_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sys_rst_i (sys_rst),
    .etick_i   (etick_i),
    .service_i (service_i),
    .rate_i    (ctrl.rate),
    .expire_o  (expire)
  );

  clkmon_ctl u_cm (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .sys_rst_i       (sys_rst),
    .mon_en_i        (ctrl.mon_en),
    .mon_force_en_i  (ctrl.mon_force_en),
    .mon_force_rst_i (ctrl.mon_force_rst),
    .rst_dis_i       (ctrl.rst_dis),
    .slow_clk_i      (slow_clk_i),
    .stop_i          (stop_i),
    .cm_rst_o        (cm_q)
  );

  rti_flag u_rti (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sys_rst_i (sys_rst),
    .set_i     (rti_timeout_i),
    .clr_i     (wr_en_i && !addr_i && wdata_i[7]),
    .flag_o    (flag)
  );

  assign wd_on   = (ctrl.rate != '0);
  assign cop_req = wd_on && !ctrl.rst_dis && (expire || ctrl.wd_force_rst);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cop_q <= 1'b0;
    else         cop_q <= cop_req && !sys_rst;
  end

  assign cop_rst_o  = cop_q;
  assign cm_rst_o   = cm_q;
  assign rti_flag_o = flag;
  assign rdata_o    = addr_i ? ctrl : {flag, 7'b0};

  p_disable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl.rst_dis |=> (!cop_rst_o && !cm_rst_o));

  p_force_cop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl.wd_force_rst && wd_on && !ctrl.rst_dis && !sys_rst) |=> cop_rst_o);

  p_cop_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cop_rst_o |=> !cop_rst_o);

  p_cop_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wd_on |=> !cop_rst_o);
endmodule

// File: tb/wdog_clkmon_ctrl_tb_top.sv
module wdog_clkmon_ctrl_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       special_mode_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic       addr_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       etick_i = 1'b0;
  logic       slow_clk_i = 1'b0;
  logic       stop_i = 1'b0;
  logic       service_i = 1'b0;
  logic       rti_timeout_i = 1'b0;
  logic       cop_rst_o, cm_rst_o, rti_flag_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam int K_RD = 0, K_COP = 1, K_CM = 2;

  typedef struct {
    int         kind;
    logic [7:0] exp;
    string      tag;
  } sb_item_t;

  sb_item_t sb_q[$];
  sb_item_t cur;
  logic [7:0] got;

  always #4 clk_i = ~clk_i;

  wdog_clkmon_ctrl #(.PRE_W(4)) dut_i (
    .clk_i, .rst_ni, .special_mode_i, .wr_en_i, .addr_i, .wdata_i, .rdata_o,
    .etick_i, .slow_clk_i, .stop_i, .service_i, .rti_timeout_i,
    .cop_rst_o, .cm_rst_o, .rti_flag_o
  );

  // monitor: pop and compare at the falling edge
  always @(negedge clk_i) begin
    while (sb_q.size() > 0) begin
      cur = sb_q.pop_front();
      case (cur.kind)
        K_RD:    got = rdata_o;
        K_COP:   got = {7'b0, cop_rst_o};
        default: got = {7'b0, cm_rst_o};
      endcase
      checks++;
      if (got !== cur.exp) begin
        errors++;
        $display("FAIL %s: got %02h expected %02h", cur.tag, got, cur.exp);
      end
    end
  end

  task automatic step();
    @(posedge clk_i); #1;
  endtask

  task automatic push_exp(input int k, input logic [7:0] e, input string tag);
    sb_item_t it;
    it.kind = k; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk_i); #1;
  endtask

  task automatic chk_rd(input logic a, input logic [7:0] e, input string tag);
    addr_i = a;
    push_exp(K_RD, e, tag);
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    step();
    wr_en_i = 1'b0;
  endtask

  task automatic do_reset(input logic sp);
    rst_ni = 1'b0; special_mode_i = sp;
    etick_i = 0; slow_clk_i = 0; stop_i = 0; service_i = 0; rti_timeout_i = 0;
    repeat (2) step();
    rst_ni = 1'b1;
    step();
  endtask

  initial begin
    repeat (60000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: bench hung, got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // ---------------- normal mode ----------------
    do_reset(1'b0);
    chk_rd(1'b1, 8'h01, "R1 ctrl reset normal");
    chk_rd(1'b0, 8'h00, "R1 flag reset");
    push_exp(K_COP, 8'h00, "R1 no cop after reset");
    push_exp(K_CM, 8'h00, "R1 no cm after reset");

    slow_clk_i = 1'b1; step(); slow_clk_i = 1'b0;
    push_exp(K_CM, 8'h00, "R8 monitor inactive ignores slow clock");

    wr(1'b1, 8'h00);
    chk_rd(1'b1, 8'h00, "R3 first write loads rate");
    wr(1'b1, 8'h47);
    chk_rd(1'b1, 8'h00, "R3 second write locked");
    wr(1'b1, 8'hB8);
    chk_rd(1'b1, 8'h80, "R2 R4 cme set, protected bits ignored");

    etick_i = 1'b1;
    for (int i = 0; i < 100; i++) begin
      step();
      push_exp(K_COP, 8'h00, "R7 rate 0 disables watchdog");
    end
    etick_i = 1'b0;

    rti_timeout_i = 1'b1; step(); rti_timeout_i = 1'b0;
    chk_rd(1'b0, 8'h80, "R10 flag set");
    wr(1'b0, 8'h7F);
    chk_rd(1'b0, 8'h80, "R10 write bit7=0 keeps flag");
    wr(1'b0, 8'h80);
    chk_rd(1'b0, 8'h00, "R10 write bit7=1 clears flag");
    rti_timeout_i = 1'b1;
    wr(1'b0, 8'h80);
    rti_timeout_i = 1'b0;
    chk_rd(1'b0, 8'h80, "R10 set wins over clear");

    slow_clk_i = 1'b1; step(); slow_clk_i = 1'b0;
    push_exp(K_CM, 8'h01, "R8 slow clock with cme");
    step();
    push_exp(K_CM, 8'h00, "R8 cm pulse one cycle");
    chk_rd(1'b1, 8'h01, "R11 ctrl back to normal reset value");
    chk_rd(1'b0, 8'h00, "R11 flag cleared by system reset");

    wr(1'b1, 8'h03);
    chk_rd(1'b1, 8'h03, "R11 write-once lock reopened");
    wr(1'b1, 8'h45);
    chk_rd(1'b1, 8'h03, "R3 locked again");

    // watchdog, rate 3 = 2^(4+6)? no: rewrite not allowed, use reset default rate 1
    do_reset(1'b0);
    etick_i = 1'b1;
    service_i = 1'b1; step(); service_i = 1'b0;
    repeat (40) step();
    service_i = 1'b1; step(); service_i = 1'b0;
    for (int i = 0; i < 63; i++) begin
      step();
      push_exp(K_COP, 8'h00, "R7 service restarts count");
    end
    step();
    etick_i = 1'b0;
    push_exp(K_COP, 8'h01, "R7 timeout after 64 ticks");
    step();
    push_exp(K_COP, 8'h00, "R7 cop pulse one cycle");
    chk_rd(1'b1, 8'h01, "R11 ctrl reset after cop");

    wr(1'b1, 8'h40);
    chk_rd(1'b1, 8'h40, "R3 force-enable loaded");
    wr(1'b1, 8'h00);
    chk_rd(1'b1, 8'h40, "R3 force-enable locked");
    stop_i = 1'b1; step(); stop_i = 1'b0;
    push_exp(K_CM, 8'h01, "R8 stop with force-enable");
    step();
    chk_rd(1'b1, 8'h01, "R11 ctrl reset after cm");

    // ---------------- special mode ----------------
    do_reset(1'b1);
    chk_rd(1'b1, 8'h09, "R1 ctrl reset special");
    wr(1'b1, 8'h89);
    slow_clk_i = 1'b1; step(); slow_clk_i = 1'b0;
    push_exp(K_CM, 8'h00, "R5 disable blocks cm");
    wr(1'b1, 8'hB9);
    chk_rd(1'b1, 8'hB9, "R4 special writes protected bits");
    step();
    push_exp(K_COP, 8'h00, "R5 disable blocks forced cop");
    push_exp(K_CM, 8'h00, "R5 disable blocks forced cm");

    wr(1'b1, 8'h10);
    step();
    push_exp(K_COP, 8'h00, "R6 force with rate 0 no effect");
    chk_rd(1'b1, 8'h10, "R4 special clears disable");
    wr(1'b1, 8'h20);
    step();
    push_exp(K_CM, 8'h00, "R9 force cm with monitor off");
    wr(1'b1, 8'h11);
    step();
    push_exp(K_COP, 8'h01, "R6 force cop");
    step();
    push_exp(K_COP, 8'h00, "R6 forced cop one cycle");
    chk_rd(1'b1, 8'h09, "R11 ctrl back to special reset value");

    wr(1'b1, 8'hA0);
    step();
    push_exp(K_CM, 8'h01, "R9 force cm with monitor on");
    step();
    chk_rd(1'b1, 8'h09, "R11 ctrl reset after forced cm");

    wr(1'b1, 8'h02);
    wr(1'b1, 8'h07);
    chk_rd(1'b1, 8'h07, "R3 special rewrites rate");
    wr(1'b1, 8'h05);
    etick_i = 1'b1;
    service_i = 1'b1; step(); service_i = 1'b0;
    repeat (8191) step();
    push_exp(K_COP, 8'h00, "R7 rate 5 no early timeout");
    step();
    etick_i = 1'b0;
    push_exp(K_COP, 8'h01, "R7 rate 5 timeout at 8192 ticks");
    step();
    push_exp(K_COP, 8'h00, "R7 rate 5 pulse one cycle");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule